// File: doc/BRIEF.md
# Power-Management Clock Divider with Switchback

This block produces the clock enable that paces a processor core. In its normal setting the enable is high on every external clock. When software writes the mode register with the slow bit set, the block drops into a low-power setting in which the enable pulses once every 1024 external clocks. Each of those pulses marks one internal cycle.

The block leaves the slow setting on its own when a wake event arrives. The three kinds of wake event are:

- a falling edge on a receive line whose port has reception enabled;
- a load of a transmit buffer, which takes effect at the next instruction boundary;
- a pending interrupt, which takes effect at the end of the current internal cycle.

An interrupt wake is held back while an instruction that writes the interrupt enable or priority registers is running. The hold lasts until the instruction after that one has completed.

The receive path reacts to any falling edge on a synchronized line. It does not check framing, address or status, so noise is enough to wake the core. A sticky status output tells software, when it polls, that an automatic exit took place.

Top module: `pmm_clkdiv`

## Requirements
- R1: After reset, slow_mode is 0, clk_en is 1 and sb_flag is 0.
- R2: While slow_mode is 0, clk_en is 1 on every clock.
- R3: A mode write with mode_wr_slow=1 sets slow_mode at that edge. Counting the first cycle after that edge as cycle 0, clk_en is 1 only in cycles where (cycle mod 1024) = 1023.
- R4: In slow mode, suppose a port's rx_line goes low before clock edge k and its rx_en bit is 1. The line passes through two synchronizer flops, and an edge is a synchronized high followed by a synchronized low. clk_en is then 1 in the cycle after edge k+1, which is the detection cycle, and slow_mode is 0 after edge k+2.
- R5: A falling edge on a port whose rx_en bit is 0 neither raises clk_en nor leaves slow mode.
- R6: A tx_load pulse in slow mode clears slow_mode at the first insn_boundary pulse in a later cycle. A boundary in the same cycle as the load does not count.
- R7: In slow mode, an asserted irq_pend with no hold in force clears slow_mode at the edge that ends the cycle in which clk_en is 1.
- R8: A cycle with prot_wr=1 blocks interrupt wakes until two further insn_boundary pulses have occurred.
- R9: Every automatic exit sets sb_flag to 1. Any mode write clears sb_flag, unless that write is refused under R10. A mode write with mode_wr_slow=0 leaves slow mode without setting sb_flag.
- R10: A mode write with mode_wr_slow=1 leaves slow_mode at 0 and sets sb_flag if a wake is pending. A pending wake is an unblocked irq_pend, a tx_load, or a transmit load still waiting for its boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wr_slow | input | 1 | Written value: 1 enters slow mode, 0 leaves it |
| rx_en | input | NUM_PORTS | Per-port reception enable |
| rx_line | input | NUM_PORTS | Asynchronous receive lines, idle high |
| tx_load | input | NUM_PORTS | Per-port transmit buffer load strobes |
| irq_pend | input | 1 | An enabled interrupt is pending |
| insn_boundary | input | 1 | Pulse at the start of each new instruction |
| prot_wr | input | 1 | Current instruction writes an interrupt enable or priority register |
| clk_en | output | 1 | Core clock enable |
| slow_mode | output | 1 | 1 while in the divide-by-1024 setting |
| sb_flag | output | 1 | Sticky indication of an automatic exit |

## Verification
The slow pacing is measured across two full internal periods, which exposes both an off-by-one in the counter and a wrong terminal count. Receive edges are driven on an enabled port and on a disabled port. This separates the enable gating from the edge detector, and the timing of the detection cycle is checked against the synchronizer depth. Transmit loads are issued together with a boundary in the same cycle and also ahead of a later boundary, to tell the deferred exit apart from an immediate one. Interrupt wakes are tried with and without the protected-write hold, which shows that the exit waits for a tick and that the hold needs exactly two boundaries to lift.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
  // Terminal count of a divider of the given width.
  function automatic logic div_is_last(input logic [15:0] cnt, input int unsigned width);
    logic [15:0] last;
    last = (16'(1) << width) - 16'(1);
    return cnt == last;
  endfunction

  // Falling edge between two successive synchronized samples.
  function automatic logic is_fall(input logic older, input logic newer);
    return older & ~newer;
  endfunction
endpackage

// File: rtl/pmm_rx_edge.sv
module pmm_rx_edge #(
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] line_i,
  output logic [NUM_PORTS-1:0] fall_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
        prev_q <= 1'b1;
      end else begin
        meta_q <= line_i[p];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign fall_o[p] = pmm_pkg::is_fall(prev_q, sync_q);
  end
endmodule

// File: rtl/pmm_divider.sv
module pmm_divider #(
  parameter int DIV_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  logic [DIV_BITS-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
    else             cnt_q <= '0;
  end

  assign tick_o = run_i & pmm_pkg::div_is_last(16'(cnt_q), DIV_BITS);
endmodule

// File: rtl/pmm_irq_gate.sv
module pmm_irq_gate #(
  parameter int HOLD_INSNS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prot_wr_i,
  input  logic boundary_i,
  output logic busy_o
);
  localparam int HW = $clog2(HOLD_INSNS + 1);
  logic [HW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                           left_q <= '0;
    else if (prot_wr_i)                   left_q <= HW'(HOLD_INSNS);
    else if (boundary_i && left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign busy_o = prot_wr_i | (left_q != '0);
endmodule

// File: rtl/pmm_clkdiv.sv
module pmm_clkdiv #(
  parameter int NUM_PORTS  = 2,
  parameter int DIV_BITS   = 10,
  parameter int HOLD_INSNS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_wr,
  input  logic                 mode_wr_slow,
  input  logic [NUM_PORTS-1:0] rx_en,
  input  logic [NUM_PORTS-1:0] rx_line,
  input  logic [NUM_PORTS-1:0] tx_load,
  input  logic                 irq_pend,
  input  logic                 insn_boundary,
  input  logic                 prot_wr,
  output logic                 clk_en,
  output logic                 slow_mode,
  output logic                 sb_flag
);
  logic                 slow_q, flag_q, tx_pend_q;
  logic                 tick, defer_busy;
  logic [NUM_PORTS-1:0] rx_fall;

  // Named internal events, observed by the checker.
  logic rx_exit_w, tx_exit_w, irq_exit_w, auto_exit_w, irq_ok_w, pend_w;

  pmm_rx_edge #(.NUM_PORTS(NUM_PORTS)) u_rx (
    .clk(clk), .rst_n(rst_n), .line_i(rx_line), .fall_o(rx_fall));

  pmm_divider #(.DIV_BITS(DIV_BITS)) u_div (
    .clk(clk), .rst_n(rst_n), .run_i(slow_q), .tick_o(tick));

  pmm_irq_gate #(.HOLD_INSNS(HOLD_INSNS)) u_irq (
    .clk(clk), .rst_n(rst_n), .prot_wr_i(prot_wr),
    .boundary_i(insn_boundary), .busy_o(defer_busy));

  assign irq_ok_w    = irq_pend & ~defer_busy;
  assign rx_exit_w   = slow_q & (|(rx_fall & rx_en));
  assign tx_exit_w   = slow_q & tx_pend_q & insn_boundary;
  assign irq_exit_w  = slow_q & tick & irq_ok_w;
  assign auto_exit_w = rx_exit_w | tx_exit_w | irq_exit_w;
  assign pend_w      = tx_pend_q | (|tx_load) | irq_ok_w | (|(rx_fall & rx_en));

  always_ff @(posedge clk) begin
    if (!rst_n)               tx_pend_q <= 1'b0;
    else if (|tx_load)        tx_pend_q <= 1'b1;
    else if (insn_boundary)   tx_pend_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slow_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (auto_exit_w) begin
      slow_q <= 1'b0;
      flag_q <= 1'b1;
    end else if (mode_wr) begin
      if (mode_wr_slow && pend_w) begin
        slow_q <= 1'b0;
        flag_q <= 1'b1;
      end else begin
        slow_q <= mode_wr_slow;
        flag_q <= 1'b0;
      end
    end
  end

  assign clk_en    = ~slow_q | tick | rx_exit_w;
  assign slow_mode = slow_q;
  assign sb_flag   = flag_q;
endmodule

// File: rtl/pmm_clkdiv_chk.sv
module pmm_clkdiv_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_wr,
  input logic clk_en,
  input logic slow_mode,
  input logic sb_flag,
  input logic rx_exit_w,
  input logic tx_exit_w,
  input logic auto_exit_w,
  input logic defer_busy
);
  AST_NORMAL_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_mode |-> clk_en); // R2

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_mode && clk_en && !auto_exit_w && !mode_wr) |=> (!clk_en || rx_exit_w)); // R3

  AST_RX_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_exit_w |-> (clk_en ##1 !slow_mode)); // R4

  AST_TX_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_exit_w |=> !slow_mode); // R6

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_mode && defer_busy && !rx_exit_w && !tx_exit_w && !mode_wr) |=> slow_mode); // R8

  AST_FLAG_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_mode && auto_exit_w) |=> (!slow_mode && sb_flag)); // R9
endmodule

bind pmm_clkdiv pmm_clkdiv_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .clk_en(clk_en),
  .slow_mode(slow_mode), .sb_flag(sb_flag), .rx_exit_w(rx_exit_w),
  .tx_exit_w(tx_exit_w), .auto_exit_w(auto_exit_w), .defer_busy(defer_busy));

// File: tb/pmm_clkdiv_tb_top.sv
module pmm_clkdiv_tb_top;
  localparam int NP = 2;
  localparam int PERIOD = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 1'b0, mode_wr_slow = 1'b0;
  logic [NP-1:0] rx_en = '0, rx_line = '1, tx_load = '0;
  logic irq_pend = 1'b0, insn_boundary = 1'b0, prot_wr = 1'b0;
  logic clk_en, slow_mode, sb_flag;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  pmm_clkdiv dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wr_slow(mode_wr_slow),
    .rx_en(rx_en), .rx_line(rx_line), .tx_load(tx_load), .irq_pend(irq_pend),
    .insn_boundary(insn_boundary), .prot_wr(prot_wr),
    .clk_en(clk_en), .slow_mode(slow_mode), .sb_flag(sb_flag));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_mode(input logic v);
    mode_wr = 1'b1; mode_wr_slow = v;
    step(1);
    mode_wr = 1'b0; mode_wr_slow = 1'b0;
  endtask

  task automatic t_reset;
    step(1);
    chk("R1 slow_mode", slow_mode, 0);
    chk("R1 clk_en", clk_en, 1);
    chk("R1 sb_flag", sb_flag, 0);
  endtask

  task automatic t_normal;
    int bad = 0;
    for (int i = 0; i < 20; i++) begin
      if (clk_en !== 1'b1) bad++;
      step(1);
    end
    chk("R2 low enables in normal mode", bad, 0);
  endtask

  task automatic t_period;
    int bad = 0;
    write_mode(1'b1);
    chk("R3 entered slow", slow_mode, 1);
    chk("R9 flag cleared by write", sb_flag, 0);
    for (int i = 0; i < 2 * PERIOD; i++) begin
      if (clk_en !== ((i % PERIOD) == PERIOD - 1)) bad++;
      step(1);
    end
    chk("R3 enable pattern mismatches", bad, 0);
    write_mode(1'b0);
    chk("R9 software exit mode", slow_mode, 0);
    chk("R9 software exit no flag", sb_flag, 0);
  endtask

  task automatic t_rx;
    rx_en = 2'b01;
    write_mode(1'b1);
    step(5);
    rx_line[0] = 1'b0;
    step(1);
    chk("R4 not yet detected", clk_en, 0);
    step(1);
    chk("R4 enable in detection cycle", clk_en, 1);
    chk("R4 still slow in detection cycle", slow_mode, 1);
    step(1);
    chk("R4 exited", slow_mode, 0);
    chk("R9 flag after rx exit", sb_flag, 1);
    rx_line[0] = 1'b1;
    step(4);
  endtask

  task automatic t_rx_disabled;
    int bad = 0;
    rx_en = 2'b01;
    write_mode(1'b1);
    rx_line[1] = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (clk_en !== 1'b0 || slow_mode !== 1'b1) bad++;
      step(1);
    end
    chk("R5 disabled port woke core", bad, 0);
    rx_line[1] = 1'b1;
    step(4);
    chk("R5 still slow after release", slow_mode, 1);
    write_mode(1'b0);
    rx_en = '0;
  endtask

  task automatic t_tx;
    write_mode(1'b1);
    tx_load[1] = 1'b1; insn_boundary = 1'b1;
    step(1);
    tx_load = '0; insn_boundary = 1'b0;
    chk("R6 same-cycle boundary ignored", slow_mode, 1);
    step(5);
    chk("R6 waits for boundary", slow_mode, 1);
    insn_boundary = 1'b1;
    step(1);
    insn_boundary = 1'b0;
    chk("R6 exit at boundary", slow_mode, 0);
    chk("R9 flag after tx exit", sb_flag, 1);
  endtask

  task automatic t_irq;
    int bad = 0;
    write_mode(1'b1);
    step(10);
    irq_pend = 1'b1;
    for (int i = 10; i < PERIOD - 1; i++) begin
      if (slow_mode !== 1'b1) bad++;
      step(1);
    end
    chk("R7 left before tick", bad, 0);
    chk("R7 tick present", clk_en, 1);
    step(1);
    chk("R7 exited after tick", slow_mode, 0);
    chk("R9 flag after irq exit", sb_flag, 1);
    irq_pend = 1'b0;
  endtask

  task automatic wait_tick;
    while (clk_en !== 1'b1) step(1);
    step(1);
  endtask

  task automatic t_defer;
    write_mode(1'b1);
    prot_wr = 1'b1;
    step(1);
    prot_wr = 1'b0; irq_pend = 1'b1;
    wait_tick();
    chk("R8 held at first tick", slow_mode, 1);
    insn_boundary = 1'b1; step(1); insn_boundary = 1'b0;
    wait_tick();
    chk("R8 held after one boundary", slow_mode, 1);
    insn_boundary = 1'b1; step(1); insn_boundary = 1'b0;
    wait_tick();
    chk("R8 released after two boundaries", slow_mode, 0);
    irq_pend = 1'b0;
  endtask

  task automatic t_pending_write;
    irq_pend = 1'b1;
    write_mode(1'b1);
    chk("R10 irq pending refuses slow", slow_mode, 0);
    chk("R10 flag on refused write", sb_flag, 1);
    irq_pend = 1'b0;
    tx_load[0] = 1'b1; step(1); tx_load = '0;
    write_mode(1'b1);
    chk("R10 tx pending refuses slow", slow_mode, 0);
    insn_boundary = 1'b1; step(1); insn_boundary = 1'b0;
    write_mode(1'b1);
    chk("R10 accepted once clear", slow_mode, 1);
    chk("R9 flag cleared on accepted write", sb_flag, 0);
    write_mode(1'b0);
  endtask

  initial begin
    fork
      begin
        step(3);
        rst_n = 1'b1;
        t_reset();
        t_normal();
        t_period();
        t_rx();
        t_rx_disabled();
        t_tx();
        t_irq();
        t_defer();
        t_pending_write();
        done = 1'b1;
      end
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          checks++; fails++;
          $display("FAIL watchdog actual=timeout expected=completion");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule